// File: doc/BRIEF.md
# Stall Distribution Buffer

This block sits between a memory pipeline and the logic that uses it. The memory controller can raise a stall in any cycle, but that stall takes a fixed number of cycles, `DIST_DLY`, to reach the consuming logic. Until the logic sees the stall, it keeps issuing requests. Meanwhile the memory, which is never halted, keeps returning read data for requests that are already in its pipeline.

The block holds requests back from the memory while the raised stall is active. It forwards the stall to the logic through a delay line of `DIST_DLY` stages. Two small FIFOs catch the traffic in flight: one for requests issued by the logic, and one for read data that arrives while the logic is stalled. When the stall ends, the queued entries are replayed in their original order, one per cycle, and ahead of any newer traffic. When nothing is queued, traffic passes straight through in the same cycle.

Typical stall lengths are handled, from a one-cycle slip up to halts of arbitrary length. The queues are sized at elaboration from the distribution delay and the memory pipeline depth. A sticky overflow flag reports any push into a full queue.

Top module: `sdb_stall_buffer`

## Requirements
- R1: `stall_dist_o` equals `stall_req_i` delayed by exactly `DIST_DLY` clock cycles, and it is low during reset and for the first `DIST_DLY` cycles after reset.
- R2: No request is presented to the memory (`mreq_valid_o` low) in any cycle in which `stall_req_i` is high.
- R3: A logic request arriving while `stall_req_i` is low and no request is queued appears on the memory side in the same cycle, with the same write flag, address and write data.
- R4: A logic request arriving while `stall_req_i` is high, or while older requests are still queued, is held and not dropped. Queued requests go to the memory one per cycle, starting in the first cycle in which `stall_req_i` is low, and this holds for stalls of 1, 4, 10 and many cycles.
- R5: The memory receives requests in exactly the order the logic issued them, so a queued request always precedes any request issued after it.
- R6: `lrd_valid_o` is never high in a cycle in which `stall_dist_o` is high. Read data arriving in such a cycle is kept.
- R7: Read data reaches the logic in the order it arrived from the memory. Kept data drains one word per cycle, from the first cycle in which `stall_dist_o` is low, ahead of newly arriving data, and no word is lost.
- R8: Read data arriving while `stall_dist_o` is low and nothing is kept is passed to the logic in the same cycle.
- R9: `ovf_o` goes high, and stays high until reset, if either queue receives a push while full. With the request queue holding at least `DIST_DLY` entries, the read queue holding at least `DIST_DLY + MEM_LAT` entries, and stalls separated by enough quiet cycles for the queues to empty, `ovf_o` stays low.
- R10: While `rst_n` is low, `mreq_valid_o`, `lrd_valid_o`, `stall_dist_o` and `ovf_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_req_i | input | 1 | Stall raised by the memory controller |
| stall_dist_o | output | 1 | Stall as seen by the logic, `DIST_DLY` cycles later |
| lreq_valid_i | input | 1 | Logic issues a request this cycle |
| lreq_we_i | input | 1 | Request is a write (1) or a read (0) |
| lreq_addr_i | input | ADDR_W | Request address |
| lreq_wdata_i | input | DATA_W | Write data |
| mreq_valid_o | output | 1 | Request presented to the memory this cycle |
| mreq_we_o | output | 1 | Write flag of the memory request |
| mreq_addr_o | output | ADDR_W | Address of the memory request |
| mreq_wdata_o | output | DATA_W | Write data of the memory request |
| mrd_valid_i | input | 1 | Memory returns a read word this cycle |
| mrd_data_i | input | DATA_W | Returned read word |
| lrd_valid_o | output | 1 | Read word delivered to the logic this cycle |
| lrd_data_o | output | DATA_W | Delivered read word |
| ovf_o | output | 1 | Sticky flag: a queue was pushed while full |

## Verification
The hardest situation to reach is a replay that overlaps live traffic. The request queue must still hold entries when new requests arrive, and kept read data must still be draining while fresh words arrive from the memory, so that ordering is decided by the queues and not by the bypass path.

The stimulus reaches this with a logic model that issues in every permitted cycle around some stalls and at half rate around others. A one-cycle stall shorter than the distribution delay makes pushes and pops share cycles. A memory model with a fixed pipeline latency keeps read words arriving throughout the drain.

// File: rtl/sdb_pkg.sv
package sdb_pkg;

   // Which source drives a lane output in the current cycle.
   typedef enum logic [1:0] {
      SRC_NONE   = 2'd0,
      SRC_QUEUE  = 2'd1,
      SRC_BYPASS = 2'd2
   } src_e;

   // Index width for a storage of n entries (at least one bit).
   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/sdb_fifo.sv
module sdb_fifo #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [WIDTH-1:0] push_data_i,
   input  logic             pop_i,
   output logic [WIDTH-1:0] head_o,
   output logic             empty_o,
   output logic             full_o,
   output logic             ovf_o
);
   import sdb_pkg::*;

   localparam int unsigned PW   = idx_width(DEPTH);
   localparam int unsigned CW   = $clog2(DEPTH + 1);
   localparam bit          POW2 = (DEPTH == (1 << PW));

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("sdb_fifo: DEPTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] store_q [DEPTH];
   logic [PW-1:0]    wr_q, rd_q, wr_nxt, rd_nxt;
   logic [CW-1:0]    cnt_q;
   logic             push_ok, pop_ok;

   assign empty_o = (cnt_q == '0);
   assign full_o  = (cnt_q == CW'(DEPTH));
   assign pop_ok  = pop_i && !empty_o;
   assign push_ok = push_i && (!full_o || pop_ok);
   assign ovf_o   = push_i && !push_ok;
   assign head_o  = store_q[rd_q];

   // Pointer advance: free-running wrap for power-of-two depths, compare otherwise.
   generate
      if (POW2) begin : g_wrap_free
         assign wr_nxt = wr_q + PW'(1);
         assign rd_nxt = rd_q + PW'(1);
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + PW'(1);
         assign rd_nxt = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) begin
         store_q[wr_q] <= push_data_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_ok) begin
            wr_q <= wr_nxt;
         end
         if (pop_ok) begin
            rd_q <= rd_nxt;
         end
         case ({push_ok, pop_ok})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

endmodule

// File: rtl/sdb_stall_delay.sv
module sdb_stall_delay #(
   parameter int unsigned DLY = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stall_i,
   output logic stall_o
);

   generate
      if (DLY < 1) begin : g_bad_dly
         $error("sdb_stall_delay: DLY must be at least 1");
      end else if (DLY == 1) begin : g_single
         logic stage_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               stage_q <= 1'b0;
            end else begin
               stage_q <= stall_i;
            end
         end
         assign stall_o = stage_q;
      end else begin : g_chain
         logic [DLY-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else begin
               chain_q <= {chain_q[DLY-2:0], stall_i};
            end
         end
         assign stall_o = chain_q[DLY-1];
      end
   endgenerate

endmodule

// File: rtl/sdb_hold_lane.sv
module sdb_hold_lane #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold_i,
   input  logic             in_valid_i,
   input  logic [WIDTH-1:0] in_data_i,
   output logic             out_valid_o,
   output logic [WIDTH-1:0] out_data_o,
   output logic             backlog_o,
   output logic             ovf_o
);
   import sdb_pkg::*;

   src_e             src;
   logic             q_push, q_pop, q_empty, q_full;
   logic [WIDTH-1:0] q_head;

   // Queued entries always win over new input; nothing leaves while held.
   always_comb begin
      if (hold_i) begin
         src = SRC_NONE;
      end else if (!q_empty) begin
         src = SRC_QUEUE;
      end else if (in_valid_i) begin
         src = SRC_BYPASS;
      end else begin
         src = SRC_NONE;
      end
   end

   assign q_push = in_valid_i && (hold_i || !q_empty);
   assign q_pop  = (src == SRC_QUEUE);

   sdb_fifo #(
      .WIDTH (WIDTH),
      .DEPTH (DEPTH)
   ) u_fifo (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (q_push),
      .push_data_i (in_data_i),
      .pop_i       (q_pop),
      .head_o      (q_head),
      .empty_o     (q_empty),
      .full_o      (q_full),
      .ovf_o       (ovf_o)
   );

   always_comb begin
      case (src)
         SRC_QUEUE: out_data_o = q_head;
         default:   out_data_o = in_data_i;
      endcase
   end

   assign out_valid_o = (src != SRC_NONE);
   assign backlog_o   = !q_empty;

   logic unused_full;
   assign unused_full = q_full;

endmodule

// File: rtl/sdb_stall_buffer.sv
module sdb_stall_buffer #(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned DIST_DLY = 3,
   parameter int unsigned MEM_LAT  = 6,
   parameter int unsigned RQ_DEPTH = DIST_DLY,
   parameter int unsigned RD_DEPTH = DIST_DLY + MEM_LAT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stall_req_i,
   output logic              stall_dist_o,
   input  logic              lreq_valid_i,
   input  logic              lreq_we_i,
   input  logic [ADDR_W-1:0] lreq_addr_i,
   input  logic [DATA_W-1:0] lreq_wdata_i,
   output logic              mreq_valid_o,
   output logic              mreq_we_o,
   output logic [ADDR_W-1:0] mreq_addr_o,
   output logic [DATA_W-1:0] mreq_wdata_o,
   input  logic              mrd_valid_i,
   input  logic [DATA_W-1:0] mrd_data_i,
   output logic              lrd_valid_o,
   output logic [DATA_W-1:0] lrd_data_o,
   output logic              ovf_o
);

   localparam int unsigned REQ_W = 1 + ADDR_W + DATA_W;

   // Sizing rules checked at elaboration.
   generate
      if (DIST_DLY < 1) begin : g_bad_dly
         $error("sdb_stall_buffer: DIST_DLY must be at least 1");
      end
      if (RQ_DEPTH < DIST_DLY) begin : g_bad_rq
         $error("sdb_stall_buffer: RQ_DEPTH below the distribution delay");
      end
      if (RD_DEPTH < DIST_DLY + MEM_LAT) begin : g_bad_rd
         $error("sdb_stall_buffer: RD_DEPTH below delay plus memory latency");
      end
   endgenerate

   logic             rq_backlog, rd_backlog;
   logic             rq_ovf, rd_ovf, ovf_q;
   logic [REQ_W-1:0] rq_in, rq_out;

   sdb_stall_delay #(
      .DLY (DIST_DLY)
   ) u_dly (
      .clk     (clk),
      .rst_n   (rst_n),
      .stall_i (stall_req_i),
      .stall_o (stall_dist_o)
   );

   assign rq_in = {lreq_we_i, lreq_addr_i, lreq_wdata_i};

   // Request lane: held by the raised stall, replayed to the memory.
   sdb_hold_lane #(
      .WIDTH (REQ_W),
      .DEPTH (RQ_DEPTH)
   ) u_req_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .hold_i      (stall_req_i),
      .in_valid_i  (lreq_valid_i),
      .in_data_i   (rq_in),
      .out_valid_o (mreq_valid_o),
      .out_data_o  (rq_out),
      .backlog_o   (rq_backlog),
      .ovf_o       (rq_ovf)
   );

   assign {mreq_we_o, mreq_addr_o, mreq_wdata_o} = rq_out;

   // Read lane: held by the distributed stall, drained to the logic.
   sdb_hold_lane #(
      .WIDTH (DATA_W),
      .DEPTH (RD_DEPTH)
   ) u_rd_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .hold_i      (stall_dist_o),
      .in_valid_i  (mrd_valid_i),
      .in_data_i   (mrd_data_i),
      .out_valid_o (lrd_valid_o),
      .out_data_o  (lrd_data_o),
      .backlog_o   (rd_backlog),
      .ovf_o       (rd_ovf)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
      end else if (rq_ovf || rd_ovf) begin
         ovf_q <= 1'b1;
      end
   end

   assign ovf_o = ovf_q;

endmodule

// File: rtl/sdb_checker.sv
module sdb_checker #(
   parameter int unsigned DIST_DLY = 3
) (
   input logic clk,
   input logic rst_n,
   input logic stall_req_i,
   input logic stall_dist_o,
   input logic mreq_valid_o,
   input logic lrd_valid_o,
   input logic ovf_o,
   input logic rq_backlog,
   input logic rd_backlog
);

   localparam int unsigned RW = $clog2(DIST_DLY + 1) + 1;

   // Saturating run lengths of the raised stall, counted over past cycles.
   logic [RW-1:0] hi_run, lo_run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_run <= '0;
         lo_run <= '0;
      end else if (stall_req_i) begin
         lo_run <= '0;
         hi_run <= (hi_run >= RW'(DIST_DLY)) ? hi_run : hi_run + RW'(1);
      end else begin
         hi_run <= '0;
         lo_run <= (lo_run >= RW'(DIST_DLY)) ? lo_run : lo_run + RW'(1);
      end
   end

   AST_LAG_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (hi_run >= RW'(DIST_DLY)) |-> stall_dist_o); // R1
   AST_LAG_LOW: assert property (@(posedge clk) disable iff (!rst_n) (lo_run >= RW'(DIST_DLY)) |-> !stall_dist_o); // R1
   AST_MEM_QUIET: assert property (@(posedge clk) disable iff (!rst_n) stall_req_i |-> !mreq_valid_o); // R2
   AST_REPLAY_PENDING: assert property (@(posedge clk) disable iff (!rst_n) (!stall_req_i && rq_backlog) |-> mreq_valid_o); // R4
   AST_LOGIC_QUIET: assert property (@(posedge clk) disable iff (!rst_n) stall_dist_o |-> !lrd_valid_o); // R6
   AST_READ_DRAIN: assert property (@(posedge clk) disable iff (!rst_n) (!stall_dist_o && rd_backlog) |-> lrd_valid_o); // R7
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) !ovf_o); // R9

endmodule

bind sdb_stall_buffer sdb_checker #(
   .DIST_DLY (DIST_DLY)
) u_sdb_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .stall_req_i  (stall_req_i),
   .stall_dist_o (stall_dist_o),
   .mreq_valid_o (mreq_valid_o),
   .lrd_valid_o  (lrd_valid_o),
   .ovf_o        (ovf_o),
   .rq_backlog   (rq_backlog),
   .rd_backlog   (rd_backlog)
);

// File: tb/sdb_stall_buffer_tb_top.sv
`timescale 1ns/1ps
module sdb_stall_buffer_tb_top;

   localparam int AW  = 16;
   localparam int DW  = 32;
   localparam int DLY = 3;
   localparam int LAT = 6;
   localparam int RQW = 1 + AW + DW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          stall_req_i;
   logic          stall_dist_o;
   logic          lreq_valid_i, lreq_we_i;
   logic [AW-1:0] lreq_addr_i;
   logic [DW-1:0] lreq_wdata_i;
   logic          mreq_valid_o, mreq_we_o;
   logic [AW-1:0] mreq_addr_o;
   logic [DW-1:0] mreq_wdata_o;
   logic          mrd_valid_i;
   logic [DW-1:0] mrd_data_i;
   logic          lrd_valid_o;
   logic [DW-1:0] lrd_data_o;
   logic          ovf_o;

   always #4 clk = ~clk;

   sdb_stall_buffer #(
      .ADDR_W   (AW),
      .DATA_W   (DW),
      .DIST_DLY (DLY),
      .MEM_LAT  (LAT)
   ) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .stall_req_i  (stall_req_i),
      .stall_dist_o (stall_dist_o),
      .lreq_valid_i (lreq_valid_i),
      .lreq_we_i    (lreq_we_i),
      .lreq_addr_i  (lreq_addr_i),
      .lreq_wdata_i (lreq_wdata_i),
      .mreq_valid_o (mreq_valid_o),
      .mreq_we_o    (mreq_we_o),
      .mreq_addr_o  (mreq_addr_o),
      .mreq_wdata_o (mreq_wdata_o),
      .mrd_valid_i  (mrd_valid_i),
      .mrd_data_i   (mrd_data_i),
      .lrd_valid_o  (lrd_valid_o),
      .lrd_data_o   (lrd_data_o),
      .ovf_o        (ovf_o)
   );

   int unsigned   n_total = 0;
   int unsigned   n_fail  = 0;
   bit            done    = 1'b0;
   int            cyc     = 0;
   bit            stall_nxt = 1'b0;
   bit            issue_en  = 1'b0;
   int            rate      = 50;
   int            arrived   = 0;
   int            delivered = 0;

   bit            hist [int];
   logic [DW-1:0] mem_sched [int];
   logic [RQW-1:0] exp_req [$];
   logic [DW-1:0]  exp_rd  [$];

   function automatic logic [DW-1:0] mdata(input logic [AW-1:0] a);
      return {~a, a};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_total++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
      end
   endtask

   // One clock cycle: drive at the falling edge, sample just before the rising edge.
   task automatic step();
      logic [RQW-1:0] item;
      logic [DW-1:0]  rword;
      int             pend_before, undeliv_before, undeliv;
      bit             exp_so;
      @(negedge clk);
      stall_req_i = stall_nxt;
      hist[cyc]   = stall_nxt;
      undeliv_before = arrived - delivered;
      if (mem_sched.exists(cyc)) begin
         mrd_valid_i = 1'b1;
         mrd_data_i  = mem_sched[cyc];
         mem_sched.delete(cyc);
         arrived++;
      end else begin
         mrd_valid_i = 1'b0;
         mrd_data_i  = '0;
      end
      undeliv = arrived - delivered;
      pend_before  = exp_req.size();
      lreq_valid_i = 1'b0;
      lreq_we_i    = 1'b0;
      lreq_addr_i  = '0;
      lreq_wdata_i = '0;
      if (!stall_dist_o && issue_en && ($urandom_range(99) < rate)) begin
         lreq_valid_i = 1'b1;
         lreq_we_i    = ($urandom_range(3) == 0);
         lreq_addr_i  = AW'($urandom);
         lreq_wdata_i = $urandom;
         exp_req.push_back({lreq_we_i, lreq_addr_i, lreq_wdata_i});
         if (!lreq_we_i) exp_rd.push_back(mdata(lreq_addr_i));
      end
      #3;
      // R1: exact lag of the distributed stall
      exp_so = (cyc >= DLY) ? hist[cyc - DLY] : 1'b0;
      check(stall_dist_o == exp_so, "R1", 64'(stall_dist_o), 64'(exp_so));
      // Memory side
      if (stall_req_i) begin
         check(!mreq_valid_o, "R2", 64'(mreq_valid_o), 64'd0);
      end else if (exp_req.size() > 0) begin
         check(mreq_valid_o, (pend_before > 0) ? "R4" : "R3", 64'(mreq_valid_o), 64'd1);
      end
      if (mreq_valid_o) begin
         if (exp_req.size() == 0) begin
            check(1'b0, "R5", 64'(mreq_addr_o), 64'd0);
         end else begin
            item = exp_req.pop_front();
            check({mreq_we_o, mreq_addr_o, mreq_wdata_o} == item, (pend_before > 0) ? "R5" : "R3",
                  64'({mreq_we_o, mreq_addr_o}), 64'(item[RQW-1:DW]));
            if (!mreq_we_o) mem_sched[cyc + LAT] = mdata(mreq_addr_o);
         end
      end
      // Logic side
      if (stall_dist_o) begin
         if (undeliv > 0) check(!lrd_valid_o, "R6", 64'(lrd_valid_o), 64'd0);
      end else if (undeliv > 0) begin
         check(lrd_valid_o, (undeliv_before > 0) ? "R7" : "R8", 64'(lrd_valid_o), 64'd1);
      end
      if (lrd_valid_o) begin
         delivered++;
         if (exp_rd.size() == 0) begin
            check(1'b0, "R7", 64'(lrd_data_o), 64'd0);
         end else begin
            rword = exp_rd.pop_front();
            check(lrd_data_o == rword, (undeliv_before > 0) ? "R7" : "R8", 64'(lrd_data_o), 64'(rword));
         end
      end
      cyc++;
   endtask

   initial begin
      int lens [12] = '{1, 4, 10, 40, 2, 10, 1, 3, 4, 25, 10, 1};
      rst_n        = 1'b0;
      stall_req_i  = 1'b0;
      lreq_valid_i = 1'b0;
      lreq_we_i    = 1'b0;
      lreq_addr_i  = '0;
      lreq_wdata_i = '0;
      mrd_valid_i  = 1'b0;
      mrd_data_i   = '0;
      repeat (3) @(negedge clk);
      #3;
      // R10: reset state
      check(!mreq_valid_o, "R10", 64'(mreq_valid_o), 64'd0);
      check(!lrd_valid_o,  "R10", 64'(lrd_valid_o),  64'd0);
      check(!stall_dist_o, "R10", 64'(stall_dist_o), 64'd0);
      check(!ovf_o,        "R10", 64'(ovf_o),        64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 12; i++) begin
         rate      = (i % 2 == 1) ? 100 : 50;
         issue_en  = 1'b1;
         stall_nxt = 1'b0;
         repeat (6) step();
         stall_nxt = 1'b1;
         repeat (lens[i]) step();
         stall_nxt = 1'b0;
         repeat (DLY + 4) step();
         issue_en = 1'b0;
         repeat (DLY + LAT + 12) step();
         check(!ovf_o, "R9", 64'(ovf_o), 64'd0);
      end
      repeat (20) step();
      check(exp_req.size() == 0, "R4", 64'(exp_req.size()), 64'd0);
      check(exp_rd.size() == 0,  "R7", 64'(exp_rd.size()),  64'd0);
      check(!ovf_o, "R9", 64'(ovf_o), 64'd0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         n_total++;
         n_fail++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end

endmodule